// File: doc/BRIEF.md
# SPI Master Engine with Per-Word Frame Control

This block is the serial engine of an SPI master. It pulls 32-bit command words from a transmit stream and shifts each one out on the serial clock and data-out pins. It samples the data-in pin into a received word for every transmitted data word. It drives exactly one of eight active-low chip-select outputs while a frame is open. Clock polarity, clock phase, the word length (1 to 16 bits), a two-stage clock divider and an internal loopback path are set through plain configuration inputs. These inputs are expected to stay constant while `busy` is high.

Each transmit word carries its data in bits 15:0 and two framing flags. Bit 31 is the end-of-frame flag. Bit 30 is the no-data flag, and it only has an effect together with bit 31. With block framing off, every data word gets its own chip-select frame. With block framing on, the chip select stays asserted from one word to the next until a word with bit 31 set has been shifted. A word with both flags set closes an open frame and shifts nothing. If the transmit stream runs dry inside an open frame, the engine keeps the chip select asserted and the clock idle until the next word arrives. Received words carry the data zero-extended in bits 15:0. Bit 31 of a received word is set when it was the first word of its frame.

The transmit stream is valid/ready. `tx_ready` is high only when enabled, when no frame is being shifted (idle, or waiting between words of an open frame), and when no received word is still waiting to be taken. A word transfers on a clock edge where `tx_valid` and `tx_ready` are both high. The receive stream is valid/ready as well. `rx_valid` stays high with `rx_data` unchanged until a clock edge with `rx_ready` high. While a received word is pending, no new transmit word is accepted, so back-pressure on the receive side stalls the transmit side.

Top module: `spi_block_master`

## Requirements
- R1: The field `cfg_size` holds the bit count minus one. Exactly `cfg_size`+1 clock pulses are produced per data word, and the low `cfg_size`+1 bits of bits 15:0 are sent most significant bit first.
- R2: A received word holds the sampled bits in its low `cfg_size`+1 positions, zeros in bits 30:16 and the bits above the word length. Bit 31 is 1 exactly when it is the first data word of its chip-select frame.
- R3: With `cfg_cpol`=0 the serial clock idles low, and with 1 it idles high. With `cfg_cpha`=0 data-in is sampled on the leading edge of each pulse and data-out changes on the trailing edge. With `cfg_cpha`=1 data-out changes on the leading edge and data-in is sampled on the trailing edge.
- R4: While a frame is open, only `cs_n[cfg_cs_sel]` is low. At most one chip select is ever low.
- R5: With `cfg_block`=0, every data word is a frame of its own, whatever bit 31 says.
- R6: With `cfg_block`=1, the chip select stays low across consecutive data words. It rises only after a word whose bit 31 is set.
- R7: A transmit word with bits 31 and 30 both set produces no clock pulses and no received word. It closes an open frame. When no frame is open, it is consumed with no effect.
- R8: Bit 30 alone is ignored: such a word is shifted like any data word and does not close the frame.
- R9: Each half period of the serial clock lasts P·(S+1) system clocks. S is `cfg_scr`. P is `cfg_presc` with bit 0 cleared, taken as 1 when that gives 0.
- R10: With `cfg_loopback`=1, the receive path samples the engine's own data-out instead of `miso`.
- R11: `busy` is high from the accepted word until the frame has closed and the engine is back to idle. When `busy` is low, all chip selects are high.
- R12: When the transmit stream is empty inside an open block frame, the chip select stays low and the serial clock stays at its idle level.
- R13: While `rx_valid` is high and `rx_ready` is low, `rx_data` holds its value and `tx_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Allows new transmit words to be accepted |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Selects which clock edge samples data-in |
| cfg_block | input | 1 | Keeps chip select asserted across words until an end-of-frame word |
| cfg_loopback | input | 1 | Feeds data-out back into the receive path |
| cfg_size | input | 4 | Word length minus one |
| cfg_cs_sel | input | 3 | Index of the chip select to drive |
| cfg_presc | input | 8 | First divider stage; bit 0 ignored, 0 acts as 1 |
| cfg_scr | input | 8 | Second divider stage, divides by value plus one |
| tx_valid | input | 1 | Transmit word available |
| tx_ready | output | 1 | Engine accepts a transmit word |
| tx_data | input | 32 | Bit 31 end-of-frame, bit 30 no-data, bits 15:0 data |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer takes the received word |
| rx_data | output | 32 | Bit 31 first-of-frame, bits 15:0 data |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 8 | Active-low chip selects |
| busy | output | 1 | Transfer or open frame in progress |

## Verification
The bench aims at the cases where the framing flags interact. An end-of-frame plus no-data word after an open frame must close it without a ninth clock pulse or a phantom received word. The same word arriving while idle must leave the pins quiet. A no-data flag without the end-of-frame flag must be shifted as data, and a wrong decode would cut the frame short. An underrun inside a block frame is held for many cycles to catch an engine that drops the chip select or leaves the clock running. The odd and zero prescaler values and the single-bit word length are also tested, since each exposes an off-by-one in the divider or the bit counter. The receive side is held off to show that a pending word freezes the transmit side instead of being overwritten.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_SHIFT = 3'd2,
    ST_HOLD  = 3'd3,
    ST_WAIT  = 3'd4,
    ST_GAP   = 3'd5
  } spim_state_e;

  localparam int WORD_W   = 32;
  localparam int EOF_BIT  = 31;
  localparam int NODAT_BIT = 30;
  localparam int FIRST_BIT = 31;
endpackage

// File: rtl/spim_rate_gen.sv
module spim_rate_gen #(
  parameter int PRESC_W = 8,
  parameter int SCR_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [PRESC_W-1:0] presc,
  input  logic [SCR_W-1:0]   scr,
  output logic               tick
);
  localparam int CW = PRESC_W + SCR_W;

  logic [PRESC_W-1:0] even_div;
  logic [PRESC_W-1:0] eff_div;
  logic [CW-1:0]      limit;
  logic [CW-1:0]      cnt;
  logic               at_end;

  // bit 0 of the prescaler is dropped; zero behaves as one
  assign even_div = {presc[PRESC_W-1:1], 1'b0};
  assign eff_div  = (even_div == '0) ? PRESC_W'(1) : even_div;
  // eff * (scr + 1) written as eff*scr + eff, fits CW bits
  assign limit    = CW'(eff_div) * CW'(scr) + CW'(eff_div);
  assign at_end   = (cnt == limit - CW'(1));
  assign tick     = run && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || at_end) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/spim_cs_decode.sv
module spim_cs_decode #(
  parameter int NCS  = 8,
  parameter int SELW = $clog2(NCS)
) (
  input  logic [SELW-1:0] sel,
  input  logic            active,
  output logic [NCS-1:0]  cs_n
);
  for (genvar g = 0; g < NCS; g++) begin : g_line
    assign cs_n[g] = !(active && (sel == SELW'(g)));
  end
endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SZW    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              block_mode,
  input  logic              loopback,
  input  logic [SZW-1:0]    size,
  input  logic              tick,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_active,
  output logic              busy,
  output logic              run
);
  localparam int HW = SZW + 1;

  spim_state_e       state;
  logic [DATA_W-1:0] tx_sr;
  logic [DATA_W-1:0] rx_sr;
  logic [HW-1:0]     half;
  logic              sclk_q;
  logic              mosi_q;
  logic              eof_q;
  logic              first_q;
  logic              rx_valid_q;
  logic [WORD_W-1:0] rx_data_q;

  logic              open_slot;
  logic              take;
  logic              no_data;
  logic [SZW-1:0]    shamt;
  logic [DATA_W-1:0] aligned;
  logic [HW-1:0]     last_half;
  logic              leading;
  logic              sample_now;
  logic              miso_in;
  logic [WORD_W-1:0] unused_tx_bits;

  assign unused_tx_bits = tx_data;

  assign open_slot  = (state == ST_IDLE) || (state == ST_WAIT);
  assign tx_ready   = enable && open_slot && !rx_valid_q;
  assign take       = tx_valid && tx_ready;
  assign no_data    = tx_data[EOF_BIT] && tx_data[NODAT_BIT];

  // left-align the active bits so the MSB of the word leaves first
  assign shamt      = SZW'(DATA_W - 1) - size;
  assign aligned    = tx_data[DATA_W-1:0] << shamt;
  assign last_half  = {size, 1'b1};
  assign leading    = !half[0];
  assign sample_now = leading ^ cpha;
  assign miso_in    = loopback ? mosi_q : miso;

  assign run       = (state == ST_SETUP) || (state == ST_SHIFT) ||
                     (state == ST_HOLD)  || (state == ST_GAP);
  assign cs_active = (state == ST_SETUP) || (state == ST_SHIFT) ||
                     (state == ST_HOLD)  || (state == ST_WAIT);
  assign busy      = (state != ST_IDLE);
  assign sclk      = (state == ST_SHIFT) ? sclk_q : cpol;
  assign mosi      = mosi_q;
  assign rx_valid  = rx_valid_q;
  assign rx_data   = rx_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      tx_sr      <= '0;
      rx_sr      <= '0;
      half       <= '0;
      sclk_q     <= 1'b0;
      mosi_q     <= 1'b0;
      eof_q      <= 1'b0;
      first_q    <= 1'b0;
      rx_valid_q <= 1'b0;
      rx_data_q  <= '0;
    end else begin
      if (rx_valid_q && rx_ready) begin
        rx_valid_q <= 1'b0;
      end
      case (state)
        ST_IDLE, ST_WAIT: begin
          if (take) begin
            if (no_data) begin
              if (state == ST_WAIT) begin
                state <= ST_GAP;
              end
            end else begin
              half    <= '0;
              sclk_q  <= cpol;
              rx_sr   <= '0;
              eof_q   <= tx_data[EOF_BIT];
              first_q <= (state == ST_IDLE);
              state   <= ST_SETUP;
              if (!cpha) begin
                mosi_q <= aligned[DATA_W-1];
                tx_sr  <= aligned << 1;
              end else begin
                tx_sr  <= aligned;
              end
            end
          end
        end
        ST_SETUP: begin
          if (tick) begin
            state <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            sclk_q <= !sclk_q;
            if (sample_now) begin
              rx_sr <= {rx_sr[DATA_W-2:0], miso_in};
            end else begin
              mosi_q <= tx_sr[DATA_W-1];
              tx_sr  <= tx_sr << 1;
            end
            if (half == last_half) begin
              state <= ST_HOLD;
            end else begin
              half <= half + HW'(1);
            end
          end
        end
        ST_HOLD: begin
          if (tick) begin
            rx_valid_q <= 1'b1;
            rx_data_q  <= {first_q, {(WORD_W-DATA_W-1){1'b0}}, rx_sr};
            state      <= (block_mode && !eof_q) ? ST_WAIT : ST_GAP;
          end
        end
        ST_GAP: begin
          if (tick) begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_block_master.sv
module spi_block_master
  import spim_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int NCS     = 8,
  parameter int PRESC_W = 8,
  parameter int SCR_W   = 8,
  localparam int SZW    = $clog2(DATA_W),
  localparam int SELW   = $clog2(NCS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_enable,
  input  logic               cfg_cpol,
  input  logic               cfg_cpha,
  input  logic               cfg_block,
  input  logic               cfg_loopback,
  input  logic [SZW-1:0]     cfg_size,
  input  logic [SELW-1:0]    cfg_cs_sel,
  input  logic [PRESC_W-1:0] cfg_presc,
  input  logic [SCR_W-1:0]   cfg_scr,
  input  logic               tx_valid,
  output logic               tx_ready,
  input  logic [WORD_W-1:0]  tx_data,
  output logic               rx_valid,
  input  logic               rx_ready,
  output logic [WORD_W-1:0]  rx_data,
  output logic               sclk,
  output logic               mosi,
  input  logic               miso,
  output logic [NCS-1:0]     cs_n,
  output logic               busy
);
  logic tick;
  logic run;
  logic cs_active;

  spim_rate_gen #(
    .PRESC_W (PRESC_W),
    .SCR_W   (SCR_W)
  ) u_rate (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .presc (cfg_presc),
    .scr   (cfg_scr),
    .tick  (tick)
  );

  spim_engine #(
    .DATA_W (DATA_W)
  ) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (cfg_enable),
    .cpol       (cfg_cpol),
    .cpha       (cfg_cpha),
    .block_mode (cfg_block),
    .loopback   (cfg_loopback),
    .size       (cfg_size),
    .tick       (tick),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .rx_data    (rx_data),
    .sclk       (sclk),
    .mosi       (mosi),
    .miso       (miso),
    .cs_active  (cs_active),
    .busy       (busy),
    .run        (run)
  );

  spim_cs_decode #(
    .NCS (NCS)
  ) u_cs (
    .sel    (cfg_cs_sel),
    .active (cs_active),
    .cs_n   (cs_n)
  );
endmodule

// File: rtl/spim_checker.sv
module spim_checker #(
  parameter int NCS = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_cpol,
  input logic [NCS-1:0] cs_n,
  input logic           sclk,
  input logic           busy,
  input logic           rx_valid,
  input logic           rx_ready,
  input logic [31:0]    rx_data,
  input logic           tx_ready
);
  AST_CS_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1); // R4
  AST_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&cs_n)); // R11
  AST_SCLK_IDLE_LVL: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n) |-> (sclk == cfg_cpol)); // R3
  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R13
  AST_NO_TAKE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !tx_ready); // R13
  AST_RX_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (rx_data[30:16] == 15'd0)); // R2
endmodule

bind spi_block_master spim_checker #(.NCS(NCS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_cpol (cfg_cpol),
  .cs_n     (cs_n),
  .sclk     (sclk),
  .busy     (busy),
  .rx_valid (rx_valid),
  .rx_ready (rx_ready),
  .rx_data  (rx_data),
  .tx_ready (tx_ready)
);

// File: tb/tb_spi_block_master.sv
module tb_spi_block_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b1;
  logic        cfg_cpol = 1'b0;
  logic        cfg_cpha = 1'b0;
  logic        cfg_block = 1'b0;
  logic        cfg_loopback = 1'b0;
  logic [3:0]  cfg_size = 4'd7;
  logic [2:0]  cfg_cs_sel = 3'd0;
  logic [7:0]  cfg_presc = 8'd2;
  logic [7:0]  cfg_scr = 8'd0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [31:0] tx_data = 32'd0;
  logic        rx_valid;
  logic        rx_ready = 1'b1;
  logic [31:0] rx_data;
  logic        sclk;
  logic        mosi;
  logic        miso;
  logic [7:0]  cs_n;
  logic        busy;

  always #5 clk = ~clk;

  spi_block_master dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_block(cfg_block), .cfg_loopback(cfg_loopback),
    .cfg_size(cfg_size), .cfg_cs_sel(cfg_cs_sel), .cfg_presc(cfg_presc),
    .cfg_scr(cfg_scr), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .sclk(sclk), .mosi(mosi), .miso(miso),
    .cs_n(cs_n), .busy(busy)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  // ---------------- slave model ----------------
  logic        cs_any;
  logic [15:0] slv_pat = 16'd0;
  logic [31:0] cap = 32'd0;
  logic [31:0] last_cap = 32'd0;
  logic [7:0]  cs_seen = 8'hFF;
  int          smp_cnt = 0;
  int          lead_cnt = 0;
  int          last_leads = 0;
  int          frames = 0;
  int          rx_cnt = 0;
  int          hp = 0;
  bit          have_edge = 1'b0;
  longint      last_t = 0;
  int          tb_n;

  assign cs_any = ~(&cs_n);
  assign tb_n   = int'(cfg_size) + 1;
  assign miso   = (smp_cnt < tb_n) ? slv_pat[4'(tb_n - 1 - smp_cnt)] : 1'b0;

  always @(cs_any) begin
    if (cs_any) begin
      cap = 32'd0; lead_cnt = 0; smp_cnt = 0; have_edge = 1'b0;
      cs_seen = cs_n; frames = frames + 1;
    end else begin
      last_cap = cap; last_leads = lead_cnt;
    end
  end

  always @(posedge sclk or negedge sclk) begin
    if (cs_any) begin
      if (have_edge) hp = int'(($time - last_t) / 10);
      last_t = $time; have_edge = 1'b1;
      if (sclk != cfg_cpol) lead_cnt = lead_cnt + 1;
      if ((sclk != cfg_cpol) ^ cfg_cpha) begin
        cap = {cap[30:0], mosi};
        smp_cnt = smp_cnt + 1;
      end
    end
  end

  always @(posedge clk) if (rx_valid && rx_ready) rx_cnt <= rx_cnt + 1;

  // ---------------- helpers ----------------
  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send_word(input logic [31:0] w);
    @(negedge clk);
    tx_data = w; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic get_rx(output logic [31:0] w);
    while (!rx_valid) @(negedge clk);
    w = rx_data;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog R11: actual %0d expected %0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  // cpol cpha size presc scr sel data pat
  typedef struct packed {
    logic       cpol; logic cpha; logic [3:0] size;
    logic [7:0] presc; logic [7:0] scr; logic [2:0] sel;
    logic [15:0] data; logic [15:0] pat;
  } vec_t;

  localparam int NV = 6;
  localparam logic [56:0] VECS [NV] = '{
    {1'b0, 1'b0, 4'd7,  8'd2, 8'd0, 3'd0, 16'h00A5, 16'h003C},
    {1'b1, 1'b0, 4'd15, 8'd0, 8'd1, 3'd3, 16'hC3F1, 16'h9E27},
    {1'b0, 1'b1, 4'd3,  8'd4, 8'd0, 3'd5, 16'hFFFA, 16'h0009},
    {1'b1, 1'b1, 4'd0,  8'd3, 8'd2, 3'd7, 16'h0001, 16'h0001},
    {1'b0, 1'b1, 4'd11, 8'd5, 8'd0, 3'd2, 16'h5ABC, 16'h0F0F},
    {1'b1, 1'b0, 4'd4,  8'd1, 8'd0, 3'd6, 16'h0013, 16'h0015}
  };

  initial begin
    logic [31:0] got;
    int f0;
    int r0;
    repeat (3) @(negedge clk);
    // reset state R11 R4 R3
    check(cs_n == 8'hFF, "R4", "cs idle in reset", {24'd0, cs_n}, 32'hFF);
    check(busy == 1'b0, "R11", "busy in reset", {31'd0, busy}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(sclk == 1'b0 && !rx_valid && tx_ready, "R3", "idle after reset",
          {29'd0, sclk, rx_valid, tx_ready}, 32'd1);

    // ---------- vector table: R1 R2 R3 R4 R9 ----------
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      int n;
      int e;
      logic [31:0] mask;
      v = vec_t'(VECS[i]);
      @(negedge clk);
      cfg_cpol = v.cpol; cfg_cpha = v.cpha; cfg_size = v.size;
      cfg_presc = v.presc; cfg_scr = v.scr; cfg_cs_sel = v.sel;
      cfg_block = 1'b0; cfg_loopback = 1'b0; slv_pat = v.pat;
      n = int'(v.size) + 1;
      mask = (32'd1 << n) - 32'd1;
      e = int'(v.presc & 8'hFE);
      if (e == 0) e = 1;
      e = e * (int'(v.scr) + 1);
      send_word({16'd0, v.data});
      get_rx(got);
      wait_idle();
      check(got == ({16'd0, v.pat} & mask | 32'h8000_0000), "R2", "rx word",
            got, ({16'd0, v.pat} & mask) | 32'h8000_0000);
      check((last_cap & mask) == ({16'd0, v.data} & mask), "R1", "mosi bits",
            last_cap & mask, {16'd0, v.data} & mask);
      check(last_leads == n, "R1", "pulse count", last_leads, n);
      check(hp == e, "R9", "half period", hp, e);
      check(cs_seen == ~(8'd1 << v.sel), "R4", "cs select",
            {24'd0, cs_seen}, {24'd0, ~(8'd1 << v.sel)});
      check(sclk == v.cpol, "R3", "sclk idle level", {31'd0, sclk}, {31'd0, v.cpol});
    end

    // ---------- loopback R10 ----------
    @(negedge clk);
    cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_size = 4'd15; cfg_presc = 8'd2;
    cfg_scr = 8'd0; cfg_cs_sel = 3'd1; cfg_loopback = 1'b1; slv_pat = 16'h0000;
    send_word(32'h0000_BEEF);
    get_rx(got);
    wait_idle();
    check(got == 32'h8000_BEEF, "R10", "loopback word", got, 32'h8000_BEEF);

    // ---------- block frame with underrun: R6 R12 R2 ----------
    @(negedge clk);
    cfg_size = 4'd7; cfg_block = 1'b1;
    f0 = frames;
    send_word(32'h0000_0011);
    get_rx(got);
    check(got == 32'h8000_0011, "R6", "first word flagged", got, 32'h8000_0011);
    repeat (40) @(negedge clk);
    check(cs_any && busy && sclk == cfg_cpol, "R12", "underrun hold",
          {29'd0, cs_any, busy, sclk}, 32'h6);
    send_word(32'h0000_0022);
    get_rx(got);
    check(got == 32'h0000_0022, "R2", "later word not flagged", got, 32'h0000_0022);
    send_word(32'h8000_0033);
    get_rx(got);
    wait_idle();
    check(got == 32'h0000_0033, "R6", "last word", got, 32'h0000_0033);
    check(frames - f0 == 1, "R6", "one frame", frames - f0, 1);
    check(last_cap[23:0] == 24'h112233 && last_leads == 24, "R6", "frame bits",
          last_cap, 32'h0011_2233);

    // ---------- end-of-frame with no data R7 ----------
    f0 = frames; r0 = rx_cnt;
    send_word(32'h0000_0044);
    get_rx(got);
    send_word(32'hC000_0000);
    wait_idle();
    repeat (5) @(negedge clk);
    check(rx_cnt - r0 == 1, "R7", "no extra rx word", rx_cnt - r0, 1);
    check(last_leads == 8 && last_cap[7:0] == 8'h44, "R7", "no extra pulses",
          last_leads, 8);
    check(frames - f0 == 1 && !cs_any, "R7", "frame closed", frames - f0, 1);

    // ---------- no-data word while idle R7 ----------
    f0 = frames; r0 = rx_cnt;
    send_word(32'hC000_0000);
    repeat (20) @(negedge clk);
    check(frames == f0 && rx_cnt == r0 && !busy, "R7", "idle skip no effect",
          frames - f0, 0);

    // ---------- bit 30 alone R8 ----------
    f0 = frames; r0 = rx_cnt;
    send_word(32'h4000_0055);
    get_rx(got);
    check(got == 32'h8000_0055 && cs_any, "R8", "skip alone shifted", got, 32'h8000_0055);
    send_word(32'h8000_0066);
    get_rx(got);
    wait_idle();
    check(last_cap[15:0] == 16'h5566 && frames - f0 == 1, "R8", "frame kept",
          last_cap, 32'h0000_5566);

    // ---------- non-block: each word its own frame R5 ----------
    @(negedge clk);
    cfg_block = 1'b0;
    f0 = frames;
    send_word(32'h0000_0077);
    get_rx(got);
    send_word(32'h0000_0088);
    get_rx(got);
    wait_idle();
    check(frames - f0 == 2, "R5", "two frames", frames - f0, 2);
    check(got == 32'h8000_0088, "R5", "second word flagged first", got, 32'h8000_0088);

    // ---------- receive back-pressure R13 R11 ----------
    @(negedge clk);
    rx_ready = 1'b0;
    send_word(32'h0000_0099);
    while (!rx_valid) @(negedge clk);
    repeat (10) @(negedge clk);
    check(rx_valid && !tx_ready && rx_data == 32'h8000_0099, "R13", "rx held",
          rx_data, 32'h8000_0099);
    wait_idle();
    check(!busy && cs_n == 8'hFF, "R11", "idle after frame", {24'd0, cs_n}, 32'hFF);
    rx_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!rx_valid && tx_ready, "R13", "released", {30'd0, rx_valid, tx_ready}, 32'd1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule